// File: doc/BRIEF.md
# Saturating Range Clamp with Sticky Saturation Flag

This block limits a 64-bit intermediate result to the numeric range of a chosen element width, 8, 16, 32 or 64 bits. It sits after an arithmetic stage, such as a shifter, whose result can go beyond the range of the destination element. A two-bit mode picks the limiting rule, and one more bit says whether the destination element is signed.

There are two families of rule. The sign-only rules return an extreme of the range, chosen from the operand's sign alone. The range rules compare the operand with the destination limits and pass it through when it fits. Every limiting event in an accepted transfer produces a one-cycle pulse. The pulse sets a sticky flag. Only a synchronous clear or reset returns the flag to zero.

The datapath has no register stage. The input side and the output side use a valid/ready handshake. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. A transfer takes place in a cycle where both valid and ready are high. While `out_ready` is low the source must hold its data, and nothing is counted.

Top module: `sat_clamp_unit`

## Requirements
- R1: The element width is 8 shifted left by `size` (0:8, 1:16, 2:32, 3:64 bits). Signed results are sign-extended to 64 bits and unsigned results are zero-extended.
- R2: With `mode`=2'b00 (signed sign-only), the output is as follows:
  - a positive input gives 2^(w-1)-1;
  - a negative input gives -2^(w-1);
  - zero gives zero.
- R3: With `mode`=2'b01 (unsigned sign-only), any nonzero input gives 2^w-1 and zero gives zero.
- R4: In both sign-only modes the saturation indication is raised exactly when the input is nonzero.
- R5: With `mode`=2'b10 (signed-source clamp), the input is compared as signed with the limits of the destination.
  - With `dst_signed`=1 the limits are -2^(w-1) and 2^(w-1)-1.
  - With `dst_signed`=0 the limits are 0 and 2^w-1.
  - A value outside the limits becomes the nearer limit and raises saturation. Any other value passes unchanged.
- R6: With `mode`=2'b11 (unsigned-source clamp), the input is compared as unsigned with the upper limit only.
  - The upper limit is 2^(w-1)-1 when `dst_signed`=1 and 2^w-1 otherwise.
  - A value above the limit becomes the limit and raises saturation.
- R7: The clamp modes (2'b10, 2'b11) with `size`=3 pass the input through unchanged and never raise saturation.
- R8: The handshake is combinational: `out_valid`=`in_valid` and `in_ready`=`out_ready`. `sat_pulse` is high only in a cycle with `in_valid` and `out_ready` both high.
- R9: `sat_flag` goes high at the clock edge that follows a cycle with `sat_pulse` high. It then stays high until a clear or reset.
- R10: `flag_clear` high drops `sat_flag` at the next edge. If `sat_pulse` is high in the same cycle, the set wins.
- R11: `rst_n` low drives `sat_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag |
| in_valid | input | 1 | Input value is present |
| in_ready | output | 1 | Block accepts the input |
| in_data | input | 64 | Intermediate value |
| mode | input | 2 | Limiting rule select |
| size | input | 2 | Element width code |
| dst_signed | input | 1 | Destination element is signed |
| out_valid | output | 1 | Clamped result is present |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | 64 | Clamped value |
| sat_pulse | output | 1 | Limiting happened in this transfer |
| flag_clear | input | 1 | Synchronous clear of the sticky flag |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
The hardest case to reach from the ports is a cycle where a clear and a saturating transfer happen together. The stimulus drives `flag_clear` together with an out-of-range value while the flag is already set, and then checks that the flag stays set. The bench also holds `out_ready` low with an out-of-range value on the input, and confirms that neither the pulse nor the flag moves. Boundary operands are placed exactly on a limit, such as -128 for a signed byte and 0xFFFFFFFF for an unsigned word, so that the comparisons cannot be off by one.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DATA_W = 64;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    RULE_SIGN_S  = 2'b00,
    RULE_SIGN_U  = 2'b01,
    RULE_CLAMP_S = 2'b10,
    RULE_CLAMP_U = 2'b11
  } rule_e;

  typedef struct packed {
    logic [DATA_W-1:0] smax;
    logic [DATA_W-1:0] smin;
    logic [DATA_W-1:0] umax;
  } limits_t;
endpackage

// File: rtl/sat_limits.sv
module sat_limits
  import sat_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [SIZE_W-1:0] size,
  output limits_t           lim
);
  localparam int SH_W = $clog2(W) + 2;
  logic [SH_W-1:0] width;

  always_comb begin
    width    = SH_W'(8) << size;
    lim.umax = {W{1'b1}} >> (SH_W'(W) - width);
    lim.smax = {W{1'b1}} >> (SH_W'(W + 1) - width);
    lim.smin = ~lim.smax;
  end
endmodule

// File: rtl/sat_select.sv
module sat_select
  import sat_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]      value,
  input  rule_e             rule,
  input  logic [SIZE_W-1:0] size,
  input  logic              dst_signed,
  input  limits_t           lim,
  output logic [W-1:0]      result,
  output logic              clipped
);
  logic [W-1:0] hi, lo;
  logic         full_width;

  always_comb begin
    hi         = dst_signed ? lim.smax : lim.umax;
    lo         = dst_signed ? lim.smin : '0;
    full_width = (size == SIZE_W'(3));
    result     = value;
    clipped    = 1'b0;
    unique case (rule)
      RULE_SIGN_S: begin
        if (value == '0) begin
          result = '0;
        end else begin
          clipped = 1'b1;
          result  = value[W-1] ? lim.smin : lim.smax;
        end
      end
      RULE_SIGN_U: begin
        if (value == '0) begin
          result = '0;
        end else begin
          clipped = 1'b1;
          result  = lim.umax;
        end
      end
      RULE_CLAMP_S: begin
        if (!full_width) begin
          if ($signed(value) > $signed(hi)) begin
            result  = hi;
            clipped = 1'b1;
          end else if ($signed(value) < $signed(lo)) begin
            result  = lo;
            clipped = 1'b1;
          end
        end
      end
      RULE_CLAMP_U: begin
        if (!full_width && (value > hi)) begin
          result  = hi;
          clipped = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
    else if (clear_i) flag_o <= 1'b0;
  end

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clear_i) |=> flag_o);
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !set_i) |=> !flag_o);
  assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit
  import sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        mode,
  input  logic [SIZE_W-1:0] size,
  input  logic              dst_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              sat_pulse,
  input  logic              flag_clear,
  output logic              sat_flag
);
  limits_t lim;
  logic    clipped;
  logic    fire;

  sat_limits #(.W(DATA_W)) u_limits (
    .size (size),
    .lim  (lim)
  );

  sat_select #(.W(DATA_W)) u_select (
    .value      (in_data),
    .rule       (rule_e'(mode)),
    .size       (size),
    .dst_signed (dst_signed),
    .lim        (lim),
    .result     (out_data),
    .clipped    (clipped)
  );

  assign fire      = in_valid & out_ready;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign sat_pulse = fire & clipped;

  sat_sticky u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (sat_pulse),
    .clear_i (flag_clear),
    .flag_o  (sat_flag)
  );

  assert_sign_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[1]) |-> (clipped == (in_data != '0)));
  assert_wide_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && size == 2'd3) |-> (!clipped && out_data == in_data));
  assert_signed_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && dst_signed && size != 2'd3) |->
      ($signed(out_data) <= $signed(lim.smax) && $signed(out_data) >= $signed(lim.smin)));
  assert_unsigned_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && size != 2'd3) |->
      (out_data <= (dst_signed ? lim.smax : lim.umax)));
  assert_pulse_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !sat_pulse);
endmodule

// File: tb/sat_clamp_unit_bench.sv
module sat_clamp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic        dst_signed = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        sat_pulse;
  logic        flag_clear = 1'b0;
  logic        sat_flag;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sat_clamp_unit u_sat_clamp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mode(mode), .size(size), .dst_signed(dst_signed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sat_pulse(sat_pulse), .flag_clear(flag_clear), .sat_flag(sat_flag)
  );

  // {mode, size, dst_signed, input, expected output, expected saturation}
  localparam int NV = 18;
  localparam logic [133:0] VEC [NV] = '{
    {2'b00, 2'd0, 1'b0, 64'h5,                64'h7F,               1'b1}, // R2
    {2'b00, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFD, 64'hFFFFFFFFFFFFFF80, 1'b1}, // R2
    {2'b00, 2'd2, 1'b0, 64'h0,                64'h0,                1'b0}, // R4
    {2'b00, 2'd3, 1'b0, 64'h1,                64'h7FFFFFFFFFFFFFFF, 1'b1}, // R1
    {2'b01, 2'd1, 1'b0, 64'h8000000000000000, 64'hFFFF,             1'b1}, // R3
    {2'b01, 2'd3, 1'b0, 64'h0,                64'h0,                1'b0}, // R3
    {2'b10, 2'd0, 1'b1, 64'h64,               64'h64,               1'b0}, // R5
    {2'b10, 2'd0, 1'b1, 64'hC8,               64'h7F,               1'b1}, // R5
    {2'b10, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFF38, 64'hFFFFFFFFFFFFFF80, 1'b1}, // R5
    {2'b10, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0,                1'b1}, // R5
    {2'b10, 2'd1, 1'b0, 64'h10000,            64'hFFFF,             1'b1}, // R5
    {2'b10, 2'd2, 1'b0, 64'hFFFFFFFF,         64'hFFFFFFFF,         1'b0}, // R5
    {2'b10, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFF80, 64'hFFFFFFFFFFFFFF80, 1'b0}, // R5
    {2'b11, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'hFF,               1'b1}, // R6
    {2'b11, 2'd1, 1'b1, 64'h8000,             64'h7FFF,             1'b1}, // R6
    {2'b11, 2'd2, 1'b1, 64'h7FFFFFFF,         64'h7FFFFFFF,         1'b0}, // R6
    {2'b10, 2'd3, 1'b1, 64'h8000000000000000, 64'h8000000000000000, 1'b0}, // R7
    {2'b11, 2'd3, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b0}  // R7
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [1:0] s, input logic d,
                       input logic [63:0] v);
    mode = m; size = s; dst_signed = d; in_data = v;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset flag", 64'(sat_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk; flag is cleared every step so each pulse is seen alone.
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][133:132], VEC[i][131:130], VEC[i][129], VEC[i][128:65]);
      in_valid = 1'b1; out_ready = 1'b1; flag_clear = 1'b0;
      #1;
      check($sformatf("R5/R6 vector %0d data", i), out_data, VEC[i][64:1]);
      check($sformatf("R4 vector %0d pulse", i), 64'(sat_pulse), 64'(VEC[i][0]));
      @(negedge clk);
      check($sformatf("R9 vector %0d flag", i), 64'(sat_flag), 64'(VEC[i][0]));
      in_valid = 1'b0; flag_clear = 1'b1;
      @(negedge clk);
      flag_clear = 1'b0;
    end

    // R8 handshake follow-through
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    check("R8 out_valid low", 64'(out_valid), 64'd0);
    check("R8 in_ready follows", 64'(in_ready), 64'd1);

    // R8 back-pressure: saturating value held while sink stalls
    drive(2'b01, 2'd0, 1'b0, 64'h3);
    in_valid = 1'b1; out_ready = 1'b0;
    #1;
    check("R8 in_ready low", 64'(in_ready), 64'd0);
    check("R8 no pulse when stalled", 64'(sat_pulse), 64'd0);
    @(negedge clk);
    check("R8 flag untouched when stalled", 64'(sat_flag), 64'd0);

    // R9 set then hold through a non-saturating transfer
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 flag set", 64'(sat_flag), 64'd1);
    drive(2'b10, 2'd1, 1'b1, 64'h10);
    @(negedge clk);
    check("R9 flag held", 64'(sat_flag), 64'd1);

    // R10 clear and set together: set wins
    drive(2'b00, 2'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    flag_clear = 1'b1;
    @(negedge clk);
    check("R10 set beats clear", 64'(sat_flag), 64'd1);

    // R10 clear alone
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 clear", 64'(sat_flag), 64'd0);
    flag_clear = 1'b0;

    // R11 reset mid-run
    drive(2'b01, 2'd2, 1'b0, 64'h1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11 async reset", 64'(sat_flag), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule